// File: doc/BRIEF.md
# Tile Instruction Dispatcher

The dispatcher steps through a program of wide instruction words held in an on-chip instruction buffer, one word per layer tile. A start pulse resets its word counter to zero. For each word it reads the buffer, inspects the control byte, and launches the DRAM loads the word needs. Up to three loads (weights, feature map and residual) go out together on independent valid/ready channels. Any load whose skip bit marks the data as already resident is not issued. Residual data is destined for the element-wise addition path and never enters convolution.

Once every issued load has reported completion, the dispatcher pulses a single execute strobe. This one strobe starts the on-chip feature fetch, the arithmetic and the result store in parallel. Their parameters are held steady from the current word. It then waits for the store engine to report completion before it fetches the next word. Words run strictly in program order, and no dependency checking takes place between them. A word can ask for a host interrupt after its store. A word carrying the halt code ends the run.

Word layout: bits [255:248] control, bits [247:128] operation parameters, bits [127:0] transfer commands. Control bits (bit 248 upward): skip weight load, skip feature-map load, skip residual load, store to execution-unit FIFO, interrupt, halt, store to global buffer, spare. Transfer command k sits at bits [24k+23:24k], with a 16-bit address in its low part and an 8-bit length above it. The command order is k=0 weights, 1 feature map, 2 residual, 3 on-chip fetch, 4 store.

Top module: `tile_dispatcher`

## Requirements
- R1: After reset the block is idle: busy, ibuf_rd_en, ld_valid, exec_start and host_irq are all low.
- R2: A start pulse while idle sets pc to 0 and asserts ibuf_rd_en in the next cycle. The buffer returns the word one cycle after the read.
- R3: Every DRAM load channel whose skip bit is clear raises ld_valid in the cycle after the word data arrives, so all such channels rise together. Each presents the address and length from its command field (k = channel index) and holds them until ld_ready.
- R4: A channel whose skip bit (word bit 248+k) is set never raises ld_valid for that word.
- R5: exec_start never precedes the last ld_done of the issued loads. It pulses in the cycle right after that last done. Channel index 0 is weights, 1 is the feature map and 2 is the residual.
- R6: A word with all three skip bits set pulses exec_start in the cycle right after its data arrives.
- R7: exec_start lasts one cycle. While it is high, exec_op carries bits [247:128], and fetch_addr/fetch_len and st_addr/st_len carry command fields 3 and 4.
- R8: st_dest encodes 0 for DRAM, 1 for global buffer (bit 254) and 2 for execution-unit FIFO (bit 251). The FIFO bit wins when both bits are set.
- R9: The next word is read only after st_done. The read happens in the cycle after st_done, at pc+1.
- R10: When a word has its interrupt bit (bit 252) set, host_irq pulses for one cycle in the cycle after st_done. Otherwise host_irq stays low.
- R11: A word with the halt bit (bit 253) ends the run. It issues no load and no execute, busy falls, and pc stays at the halt word's address.
- R12: A start pulse while busy is ignored. The program continues from its current position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a program at word 0 |
| busy | output | 1 | Program running |
| pc | output | PC_W | Word counter, also the buffer read address |
| ibuf_rd_en | output | 1 | Instruction buffer read strobe |
| ibuf_data | input | 256 | Word returned one cycle after the read |
| ld_valid | output | 3 | Load request valid per channel |
| ld_ready | input | 3 | Load engine accepts request |
| ld_addr | output | 3*ADDR_W | Load addresses, channel k at slice k |
| ld_len | output | 3*LEN_W | Load lengths, channel k at slice k |
| ld_done | input | 3 | Load completion pulse per channel |
| exec_start | output | 1 | Starts fetch, compute and store together |
| exec_op | output | 120 | Operation parameters |
| fetch_addr | output | ADDR_W | On-chip feature fetch address |
| fetch_len | output | LEN_W | On-chip feature fetch length |
| st_addr | output | ADDR_W | Store address |
| st_len | output | LEN_W | Store length |
| st_dest | output | 2 | Store destination code |
| st_done | input | 1 | Store completion pulse |
| host_irq | output | 1 | One-cycle interrupt to the host |

## Verification
The assertions assume that each load engine pulses ld_done only after the cycle in which its request was accepted. They also assume that st_done arrives only after exec_start, and that the instruction buffer returns data exactly one cycle after a read. The bench engine models respect these rules by construction. Each engine schedules its done pulse at least one cycle after its handshake or strobe. The buffer model registers the addressed word on every read.

// File: rtl/vdsp_pkg.sv
`timescale 1ns/1ps
package vdsp_pkg;
  localparam int WORD_W    = 256;
  localparam int CTRL_LSB  = 248;
  localparam int OP_LSB    = 128;
  localparam int OP_W      = CTRL_LSB - OP_LSB;
  localparam int XFER_W    = OP_LSB;
  localparam int N_LD      = 3;

  typedef enum logic [1:0] {
    DEST_DRAM   = 2'd0,
    DEST_GBUF   = 2'd1,
    DEST_EUFIFO = 2'd2
  } st_dest_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_LOAD, S_EXEC, S_WAIT_ST
  } seq_state_e;

  // control byte, MSB first
  typedef struct packed {
    logic       spare;
    logic       st_gbuf;
    logic       halt;
    logic       irq;
    logic       st_eu;
    logic [2:0] skip;   // [0] weights, [1] feature map, [2] residual
  } ctrl_t;

  function automatic ctrl_t get_ctrl(input logic [WORD_W-1:0] w);
    return ctrl_t'(w[WORD_W-1:CTRL_LSB]);
  endfunction

  function automatic st_dest_e pick_dest(input ctrl_t c);
    if (c.st_eu)   return DEST_EUFIFO;
    if (c.st_gbuf) return DEST_GBUF;
    return DEST_DRAM;
  endfunction
endpackage

// File: rtl/vdsp_field_decode.sv
`timescale 1ns/1ps
module vdsp_field_decode import vdsp_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic [WORD_W-1:0]      word,
  output logic [N_LD*ADDR_W-1:0] ld_addr,
  output logic [N_LD*LEN_W-1:0]  ld_len,
  output logic [ADDR_W-1:0]      fetch_addr,
  output logic [LEN_W-1:0]       fetch_len,
  output logic [ADDR_W-1:0]      st_addr,
  output logic [LEN_W-1:0]       st_len,
  output logic [OP_W-1:0]        op
);
  localparam int CMD_W    = ADDR_W + LEN_W;
  localparam int N_CMD    = N_LD + 2;
  localparam int FETCH_IX = N_LD;
  localparam int STORE_IX = N_LD + 1;
  localparam int USED_W   = N_CMD * CMD_W;

  genvar k;
  generate
    for (k = 0; k < N_LD; k++) begin : g_ld
      assign ld_addr[k*ADDR_W +: ADDR_W] = word[k*CMD_W +: ADDR_W];
      assign ld_len[k*LEN_W +: LEN_W]    = word[k*CMD_W + ADDR_W +: LEN_W];
    end
    if (USED_W < XFER_W) begin : g_spare
      logic unused_xfer;
      assign unused_xfer = ^word[XFER_W-1:USED_W];
    end
  endgenerate

  assign fetch_addr = word[FETCH_IX*CMD_W +: ADDR_W];
  assign fetch_len  = word[FETCH_IX*CMD_W + ADDR_W +: LEN_W];
  assign st_addr    = word[STORE_IX*CMD_W +: ADDR_W];
  assign st_len     = word[STORE_IX*CMD_W + ADDR_W +: LEN_W];
  assign op         = word[CTRL_LSB-1:OP_LSB];
endmodule

// File: rtl/vdsp_load_chan.sv
`timescale 1ns/1ps
module vdsp_load_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic need,
  input  logic ready,
  input  logic done,
  output logic valid,
  output logic complete
);
  logic need_q, issued_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_q   <= 1'b0;
      issued_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (arm) begin
      need_q   <= need;
      issued_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (valid && ready) issued_q <= 1'b1;
      if (need_q && issued_q && done) done_q <= 1'b1;
    end
  end

  assign valid    = need_q && !issued_q;
  assign complete = !need_q || done_q || (issued_q && done);
endmodule

// File: rtl/vdsp_seq.sv
`timescale 1ns/1ps
module vdsp_seq import vdsp_pkg::*; #(
  parameter int PC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            halt_in,
  input  logic            all_skip_in,
  input  logic            loads_done,
  input  logic            st_done,
  input  logic            irq_bit,
  output logic            busy,
  output logic            rd_en,
  output logic            decode_go,
  output logic            exec_start,
  output logic            irq,
  output logic [PC_W-1:0] pc
);
  seq_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc    <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          pc    <= '0;
          state <= S_FETCH;
        end
        S_FETCH:  state <= S_DECODE;
        S_DECODE: begin
          if (halt_in)          state <= S_IDLE;
          else if (all_skip_in) state <= S_EXEC;
          else                  state <= S_LOAD;
        end
        S_LOAD:   if (loads_done) state <= S_EXEC;
        S_EXEC:   state <= S_WAIT_ST;
        S_WAIT_ST: if (st_done) begin
          irq   <= irq_bit;
          pc    <= pc + 1'b1;
          state <= S_FETCH;
        end
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign rd_en      = (state == S_FETCH);
  assign decode_go  = (state == S_DECODE) && !halt_in;
  assign exec_start = (state == S_EXEC);
endmodule

// File: rtl/tile_dispatcher.sv
`timescale 1ns/1ps
module tile_dispatcher import vdsp_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int PC_W   = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   busy,
  output logic [PC_W-1:0]        pc,
  output logic                   ibuf_rd_en,
  input  logic [WORD_W-1:0]      ibuf_data,
  output logic [N_LD-1:0]        ld_valid,
  input  logic [N_LD-1:0]        ld_ready,
  output logic [N_LD*ADDR_W-1:0] ld_addr,
  output logic [N_LD*LEN_W-1:0]  ld_len,
  input  logic [N_LD-1:0]        ld_done,
  output logic                   exec_start,
  output logic [OP_W-1:0]        exec_op,
  output logic [ADDR_W-1:0]      fetch_addr,
  output logic [LEN_W-1:0]       fetch_len,
  output logic [ADDR_W-1:0]      st_addr,
  output logic [LEN_W-1:0]       st_len,
  output logic [1:0]             st_dest,
  input  logic                   st_done,
  output logic                   host_irq
);
  ctrl_t             in_ctrl;
  ctrl_t             cur_ctrl;
  logic [WORD_W-1:0] word_q;
  logic              decode_go;
  logic              loads_done;
  logic [N_LD-1:0]   chan_complete;

  assign in_ctrl = get_ctrl(ibuf_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_q <= '0;
    else if (decode_go) word_q <= ibuf_data;
  end

  assign cur_ctrl = get_ctrl(word_q);

  vdsp_field_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
    .word       (word_q),
    .ld_addr    (ld_addr),
    .ld_len     (ld_len),
    .fetch_addr (fetch_addr),
    .fetch_len  (fetch_len),
    .st_addr    (st_addr),
    .st_len     (st_len),
    .op         (exec_op)
  );

  genvar g;
  generate
    for (g = 0; g < N_LD; g++) begin : g_ch
      vdsp_load_chan u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (decode_go),
        .need     (!in_ctrl.skip[g]),
        .ready    (ld_ready[g]),
        .done     (ld_done[g]),
        .valid    (ld_valid[g]),
        .complete (chan_complete[g])
      );
    end
  endgenerate

  assign loads_done = &chan_complete;

  vdsp_seq #(.PC_W(PC_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .halt_in     (in_ctrl.halt),
    .all_skip_in (&in_ctrl.skip),
    .loads_done  (loads_done),
    .st_done     (st_done),
    .irq_bit     (cur_ctrl.irq),
    .busy        (busy),
    .rd_en       (ibuf_rd_en),
    .decode_go   (decode_go),
    .exec_start  (exec_start),
    .irq         (host_irq),
    .pc          (pc)
  );

  assign st_dest = pick_dest(cur_ctrl);

  logic unused_ctrl;
  assign unused_ctrl = cur_ctrl.spare ^ cur_ctrl.halt ^ (^cur_ctrl.skip) ^
                       in_ctrl.spare ^ in_ctrl.irq ^ in_ctrl.st_eu ^ in_ctrl.st_gbuf;
endmodule

// File: rtl/tile_dispatcher_chk.sv
`timescale 1ns/1ps
module tile_dispatcher_chk #(
  parameter int ADDR_W = 16,
  parameter int PC_W   = 10,
  parameter int NCH    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic [PC_W-1:0]   pc,
  input logic              ibuf_rd_en,
  input logic [NCH-1:0]    ld_valid,
  input logic [NCH-1:0]    ld_ready,
  input logic [NCH*ADDR_W-1:0] ld_addr,
  input logic              exec_start,
  input logic [1:0]        st_dest,
  input logic              host_irq,
  input logic              loads_done
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ld_valid == '0 && !exec_start && !ibuf_rd_en));

  // R2
  start_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (ibuf_rd_en && pc == '0));

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_hold
      // R3
      req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid[c] && !ld_ready[c]) |=> (ld_valid[c] && $stable(ld_addr[c*ADDR_W +: ADDR_W])));
    end
  endgenerate

  // R5
  load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> (ld_valid == '0 && $past(loads_done)));

  // R7
  exec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !exec_start);

  // R8
  dest_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> (st_dest != 2'd3));

  // R9
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ibuf_rd_en |=> !ibuf_rd_en);

  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);
endmodule

bind tile_dispatcher tile_dispatcher_chk #(.ADDR_W(ADDR_W), .PC_W(PC_W), .NCH(vdsp_pkg::N_LD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .pc         (pc),
  .ibuf_rd_en (ibuf_rd_en),
  .ld_valid   (ld_valid),
  .ld_ready   (ld_ready),
  .ld_addr    (ld_addr),
  .exec_start (exec_start),
  .st_dest    (st_dest),
  .host_irq   (host_irq),
  .loads_done (loads_done)
);

// File: tb/tile_dispatcher_bench.sv
`timescale 1ns/1ps
module tile_dispatcher_bench;
  localparam int AW = 16, LW = 8, PW = 10, CW = AW + LW;
  localparam logic [7:0] C_SKW = 8'h01, C_SKF = 8'h02, C_SKR = 8'h04, C_EU = 8'h08,
                         C_IRQ = 8'h10, C_HALT = 8'h20, C_GB = 8'h40;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           busy;
  logic [PW-1:0]  pc;
  logic           ibuf_rd_en;
  logic [255:0]   ibuf_data = '0;
  logic [2:0]     ld_valid;
  logic [2:0]     ld_ready = '0;
  logic [3*AW-1:0] ld_addr;
  logic [3*LW-1:0] ld_len;
  logic [2:0]     ld_done = '0;
  logic           exec_start;
  logic [119:0]   exec_op;
  logic [AW-1:0]  fetch_addr, st_addr;
  logic [LW-1:0]  fetch_len, st_len;
  logic [1:0]     st_dest;
  logic           st_done = 1'b0;
  logic           host_irq;

  tile_dispatcher #(.ADDR_W(AW), .LEN_W(LW), .PC_W(PW)) u_tile_dispatcher (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .pc(pc),
    .ibuf_rd_en(ibuf_rd_en), .ibuf_data(ibuf_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_len(ld_len),
    .ld_done(ld_done), .exec_start(exec_start), .exec_op(exec_op),
    .fetch_addr(fetch_addr), .fetch_len(fetch_len), .st_addr(st_addr), .st_len(st_len),
    .st_dest(st_dest), .st_done(st_done), .host_irq(host_irq)
  );

  always #2.5 clk = ~clk;

  logic [255:0] mem [0:15];
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ibuf_rd_en) ibuf_data <= mem[pc[3:0]];
  end

  int n_chk = 0, n_bad = 0;
  int rdy_dly [3], dn_dly [3], st_dly;
  int first_valid [3], hs_cnt [3], dn_at [3], wcnt [3];
  logic [AW-1:0] hs_addr [3];
  logic [LW-1:0] hs_len [3];
  int exec_cnt, exec_cyc, st_at, irq_cnt, irq_cyc, rd_cnt, start_cyc;
  int rd_cyc [8], rd_addr [8];
  logic [119:0] ex_op;
  logic [AW-1:0] ex_faddr, ex_saddr;
  logic [LW-1:0] ex_flen, ex_slen;
  logic [1:0] ex_dest;

  // monitor and engine models, evaluated away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      ld_ready = '0; ld_done = '0; st_done = 1'b0;
    end else begin
      if (ibuf_rd_en) begin
        if (rd_cnt < 8) begin rd_cyc[rd_cnt] = cyc; rd_addr[rd_cnt] = int'(pc); end
        rd_cnt++;
      end
      for (int c = 0; c < 3; c++) begin
        ld_done[c] = (dn_at[c] == cyc);
        if (ld_valid[c]) begin
          if (first_valid[c] < 0) first_valid[c] = cyc;
          if (wcnt[c] >= rdy_dly[c]) begin
            ld_ready[c] = 1'b1;
            hs_cnt[c]++;
            hs_addr[c] = ld_addr[c*AW +: AW];
            hs_len[c]  = ld_len[c*LW +: LW];
            dn_at[c]   = cyc + dn_dly[c];
            wcnt[c]    = 0;
          end else begin
            ld_ready[c] = 1'b0;
            wcnt[c]++;
          end
        end else ld_ready[c] = 1'b0;
      end
      if (exec_start) begin
        exec_cnt++; exec_cyc = cyc; ex_op = exec_op;
        ex_faddr = fetch_addr; ex_flen = fetch_len;
        ex_saddr = st_addr; ex_slen = st_len; ex_dest = st_dest;
        st_at = cyc + st_dly;
      end
      st_done = (st_at == cyc);
      if (host_irq) begin irq_cnt++; irq_cyc = cyc; end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] mk_word(input logic [7:0] ctl, input int seed);
    logic [255:0] w = '0;
    w[255:248] = ctl;
    for (int j = 0; j < 4; j++) w[128 + j*30 +: 30] = 30'(seed * 32'h0135_79BD + j * 32'h0F0F_1234);
    for (int k = 0; k < 5; k++) begin
      w[k*CW +: AW]      = AW'(seed * 16'h0111 + k * 16'h1001);
      w[k*CW + AW +: LW] = LW'(seed + k * 3 + 1);
    end
    return w;
  endfunction

  task automatic clear_mon();
    for (int c = 0; c < 3; c++) begin
      first_valid[c] = -1; hs_cnt[c] = 0; dn_at[c] = -1; wcnt[c] = 0;
    end
    exec_cnt = 0; exec_cyc = -1; st_at = -1; irq_cnt = 0; irq_cyc = -1; rd_cnt = 0;
  endtask

  task automatic run_prog(input int inject);
    int k;
    @(posedge clk); #1;
    clear_mon();
    start = 1'b1; start_cyc = cyc;
    @(posedge clk); #1;
    start = 1'b0;
    k = 0;
    while (busy) begin
      @(posedge clk); #1;
      k++;
      start = (k == inject);
    end
    start = 1'b0;
  endtask

  task automatic run_single(input logic [7:0] ctl, input int seed,
                            input int r0, input int r1, input int r2,
                            input int d0, input int d1, input int d2, input int sd);
    logic [255:0] w;
    int f, last, ex, d, edest;
    w = mk_word(ctl, seed);
    mem[0] = w; mem[1] = mk_word(C_HALT, 77);
    rdy_dly[0] = r0; rdy_dly[1] = r1; rdy_dly[2] = r2;
    dn_dly[0] = d0; dn_dly[1] = d1; dn_dly[2] = d2; st_dly = sd;
    run_prog(0);
    f = rd_cyc[0];
    chk("R2", "first read cycle", f, start_cyc + 1);
    chk("R2", "first read address", rd_addr[0], 0);
    last = -1;
    for (int c = 0; c < 3; c++) begin
      if (ctl[c]) begin
        chk("R4", "skipped channel handshakes", hs_cnt[c], 0);
        chk("R4", "skipped channel valid seen", first_valid[c], -1);
      end else begin
        chk("R3", "valid rise cycle", first_valid[c], f + 2);
        chk("R3", "handshakes", hs_cnt[c], 1);
        chk("R3", "load address", hs_addr[c], w[c*CW +: AW]);
        chk("R3", "load length", hs_len[c], w[c*CW + AW +: LW]);
        d = f + 2 + rdy_dly[c] + dn_dly[c];
        if (d > last) last = d;
      end
    end
    ex = (last < 0) ? f + 2 : last + 1;
    chk((last < 0) ? "R6" : "R5", "exec cycle", exec_cyc, ex);
    chk("R7", "exec count", exec_cnt, 1);
    chk("R7", "op params match", (ex_op == w[247:128]) ? 1 : 0, 1);
    chk("R7", "fetch address", ex_faddr, w[3*CW +: AW]);
    chk("R7", "fetch length", ex_flen, w[3*CW + AW +: LW]);
    chk("R7", "store address", ex_saddr, w[4*CW +: AW]);
    chk("R7", "store length", ex_slen, w[4*CW + AW +: LW]);
    edest = ctl[3] ? 2 : (ctl[6] ? 1 : 0);
    chk("R8", "store destination", ex_dest, edest);
    chk("R9", "read count", rd_cnt, 2);
    chk("R9", "next read cycle", rd_cyc[1], ex + sd + 1);
    chk("R9", "next read address", rd_addr[1], 1);
    if (ctl[4]) begin
      chk("R10", "irq count", irq_cnt, 1);
      chk("R10", "irq cycle", irq_cyc, ex + sd + 1);
    end else chk("R10", "irq absent", irq_cnt, 0);
    chk("R11", "busy after halt", busy, 0);
    chk("R11", "pc at halt word", pc, 1);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "valid in reset", ld_valid, 0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "read after reset", ibuf_rd_en, 0);
    chk("R1", "exec after reset", exec_start, 0);
    chk("R1", "irq after reset", host_irq, 0);
  endtask

  task automatic t_all_loads();
    run_single(8'h00, 1, 0, 2, 1, 3, 1, 5, 4);
  endtask

  task automatic t_partial_skip();
    run_single(C_SKW | C_SKR | C_GB | C_IRQ, 2, 1, 0, 0, 2, 2, 2, 3);
  endtask

  task automatic t_all_skip();
    run_single(C_SKW | C_SKF | C_SKR | C_EU | C_GB, 3, 0, 0, 0, 1, 1, 1, 2);
  endtask

  task automatic t_halt_first();
    mem[0] = mk_word(C_HALT, 5);
    run_prog(0);
    chk("R11", "halt word exec count", exec_cnt, 0);
    chk("R11", "halt word handshakes", hs_cnt[0] + hs_cnt[1] + hs_cnt[2], 0);
    chk("R11", "halt word reads", rd_cnt, 1);
    chk("R11", "halt pc", pc, 0);
  endtask

  task automatic t_program();
    mem[0] = mk_word(8'h00, 11);
    mem[1] = mk_word(C_SKF | C_IRQ, 12);
    mem[2] = mk_word(C_SKW | C_SKF | C_SKR | C_IRQ, 13);
    mem[3] = mk_word(C_HALT, 14);
    rdy_dly[0] = 1; rdy_dly[1] = 0; rdy_dly[2] = 2;
    dn_dly[0] = 2; dn_dly[1] = 4; dn_dly[2] = 1; st_dly = 3;
    run_prog(6);
    chk("R12", "reads despite second start", rd_cnt, 4);
    for (int i = 0; i < 4; i++) chk("R9", "program read address", rd_addr[i], i);
    chk("R12", "exec count", exec_cnt, 3);
    chk("R10", "irq count", irq_cnt, 2);
    chk("R4", "weight handshakes", hs_cnt[0], 2);
    chk("R4", "feature handshakes", hs_cnt[1], 1);
    chk("R4", "residual handshakes", hs_cnt[2], 2);
    chk("R11", "final pc", pc, 3);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    clear_mon();
    for (int c = 0; c < 3; c++) begin rdy_dly[c] = 0; dn_dly[c] = 1; end
    st_dly = 1;
    t_reset();
    t_all_loads();
    t_partial_skip();
    t_all_skip();
    t_halt_first();
    t_program();
    t_all_loads();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule